// File: doc/BRIEF.md
# Active Antenna Power Supervisor

This block switches the supply of an active GPS antenna and watches two active-low DC sense lines. One line reports a short on the antenna feed. The other reports that an antenna is drawing current. When a short is confirmed, the supply is cut and held off for a retry interval. The supply is then switched on once to test the line again. If the short is still there at the end of that test, the block latches a fault that stays until it is cleared. While the supply is on and no short is present, a current line that stays high means no antenna is drawing current, and the block reports an open circuit.

The current-sense signal can arrive on either of two pins. Three strap bits, captured while reset is held, choose which pin is used. Some strap codes are reserved. These fall back to the second pin and raise a configuration error. Each sense line passes through a synchronizer and a debounce filter before the control state machine acts on it. The filter length, synchronizer depth and retry interval are all parameters.

Top module: `antenna_supervisor`

## Requirements
- R1: The strap code is loaded on every clock edge while `rst_n` is low and is held unchanged after reset is released. Later changes on `strap_i` do not affect pin selection.
- R2: The strap code is read as `strap_i[2]`=mode11, `strap_i[1]`=mode10, `strap_i[0]`=mode8. Codes 000, 001, 110 and 111 take current sense from `cur_a_n_i`. Code 011 takes it from `cur_b_n_i`. Codes 010, 100 and 101 also take it from `cur_b_n_i` and set `cfg_err_o`.
- R3: A sense level must be seen for DEB_CYCLES consecutive synchronized cycles before the block acts on it. Shorter pulses are ignored.
- R4: The reset state is: supply on, `ok_o`=1, and `short_o`, `open_o`, `off_o`, `fault_o` all 0.
- R5: A confirmed low on `short_n_i` while the supply is on drives `ant_pwr_o` low on the next cycle, with `short_o`=1 and `off_o`=1.
- R6: While the supply is off for a retry, low levels on both sense inputs raise no fault and no open indication.
- R7: After RETRY_CYCLES cycles off, the supply is switched on once for a probe window. If no short is seen at the end of the window, the block returns to normal operation with `ok_o`=1.
- R8: A short still present at the end of the probe window sets `fault_o` and keeps the supply off, whatever the sense inputs do, until `fault_clr_i` is pulsed.
- R9: A pulse on `fault_clr_i` in the fault state starts one probe window. A healthy line then returns the block to normal operation.
- R10: With the supply on and no short present, a current-sense level held high for the debounce period sets `open_o`. The supply stays on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. The strap is loaded while this is low. |
| strap_i | input | 3 | Strap bits {mode11, mode10, mode8} |
| short_n_i | input | 1 | Short sense, low = DC short present |
| cur_a_n_i | input | 1 | Current sense pin A, low = antenna drawing current |
| cur_b_n_i | input | 1 | Current sense pin B, low = antenna drawing current |
| fault_clr_i | input | 1 | Single-cycle pulse that clears a latched fault |
| ant_pwr_o | output | 1 | Antenna supply enable, high = on |
| ok_o | output | 1 | Supply on, antenna present, no short |
| short_o | output | 1 | Supply cut because of a short |
| open_o | output | 1 | Supply on, but no current drawn |
| off_o | output | 1 | Supply is off |
| fault_o | output | 1 | Sticky fault: short persisted at retry |
| cfg_err_o | output | 1 | A reserved strap code was latched |

## Verification
All eight strap codes are swept. A wrong decode would pick the wrong pin, which shows up as a false open indication, or would flag a legal code as an error. Sense pulses shorter than the debounce length are applied to both lines. A filter that is too short would cut the supply or report an open on a glitch. The retry path is exercised in three ways: with the short cleared during the off period, with the short persisting through the probe, and through a fault clear. A block that treated the expected low senses during the off period as a new short would never leave the off state. A block without a sticky fault would switch the supply back on into a short once the sense inputs changed.

// File: rtl/ant_sup_pkg.sv
package ant_sup_pkg;

   typedef enum logic [1:0] {
      ST_ON    = 2'd0,
      ST_WAIT  = 2'd1,
      ST_PROBE = 2'd2,
      ST_FAULT = 2'd3
   } sup_state_t;

   // Returns {use_pin_b, reserved_code}
   function automatic logic [1:0] decode_strap(input logic [2:0] code);
      logic [1:0] r;
      case (code)
         3'b000, 3'b001, 3'b110, 3'b111: r = 2'b00;
         3'b011:                         r = 2'b10;
         default:                        r = 2'b11;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ant_filter.sv
module ant_filter #(
   parameter int   SYNC_STAGES = 2,
   parameter int   DEB_CYCLES  = 16,
   parameter logic RST_LVL     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic lvl_o
);
   localparam int CW = $clog2(DEB_CYCLES + 1);

   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("ant_filter: SYNC_STAGES must be at least 1");
   end
   if (DEB_CYCLES < 1) begin : g_bad_deb
      $error("ant_filter: DEB_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          cnt;
   logic                   samp;

   if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sync_q <= RST_LVL;
         else        sync_q <= raw_i;
   end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) sync_q <= {SYNC_STAGES{RST_LVL}};
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
   end

   assign samp = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_o <= RST_LVL;
         cnt   <= '0;
      end else if (samp == lvl_o) begin
         cnt <= '0;
      end else if (cnt == CW'(DEB_CYCLES - 1)) begin
         lvl_o <= samp;
         cnt   <= '0;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

   // R3
   lvl_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_o != $past(lvl_o)) |-> ($past(cnt) == CW'(DEB_CYCLES - 1)));

endmodule

// File: rtl/ant_src_sel.sv
module ant_src_sel
   import ant_sup_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] strap_i,
   input  logic       cur_a_n,
   input  logic       cur_b_n,
   output logic       cur_n_o,
   output logic       cfg_err_o
);
   logic [2:0] strap_q;
   logic [1:0] dec;

   // Strap is loaded while reset is held and frozen afterwards.
   always_ff @(posedge clk)
      if (!rst_n) strap_q <= strap_i;

   assign dec       = decode_strap(strap_q);
   assign cur_n_o   = dec[1] ? cur_b_n : cur_a_n;
   assign cfg_err_o = dec[0];

   // R2
   rsvd_to_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err_o |-> (cur_n_o == cur_b_n));

endmodule

// File: rtl/ant_sup_fsm.sv
module ant_sup_fsm
   import ant_sup_pkg::*;
#(
   parameter int RETRY_CYCLES = 50000,
   parameter int PROBE_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic short_lvl,
   input  logic cur_lvl,
   input  logic fault_clr,
   output logic pwr_en,
   output logic st_ok,
   output logic st_short,
   output logic st_open,
   output logic st_off,
   output logic st_fault
);
   localparam int LONGEST = (RETRY_CYCLES > PROBE_CYCLES) ? RETRY_CYCLES : PROBE_CYCLES;
   localparam int TW      = $clog2(LONGEST + 1);

   if (RETRY_CYCLES < 1 || PROBE_CYCLES < 1) begin : g_bad_len
      $error("ant_sup_fsm: interval lengths must be at least 1");
   end

   sup_state_t    state;
   logic [TW-1:0] tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_ON;
         tmr   <= '0;
      end else begin
         case (state)
            ST_ON: begin
               tmr <= '0;
               if (!short_lvl) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (tmr == TW'(RETRY_CYCLES - 1)) begin
                  state <= ST_PROBE;
                  tmr   <= '0;
               end else begin
                  tmr <= tmr + TW'(1);
               end
            end
            ST_PROBE: begin
               if (tmr == TW'(PROBE_CYCLES - 1)) begin
                  state <= short_lvl ? ST_ON : ST_FAULT;
                  tmr   <= '0;
               end else begin
                  tmr <= tmr + TW'(1);
               end
            end
            default: begin
               tmr <= '0;
               if (fault_clr) state <= ST_PROBE;
            end
         endcase
      end
   end

   assign pwr_en   = (state == ST_ON) || (state == ST_PROBE);
   assign st_off   = !pwr_en;
   assign st_short = (state == ST_WAIT) || (state == ST_FAULT);
   assign st_fault = (state == ST_FAULT);
   assign st_ok    = (state == ST_ON) && short_lvl && !cur_lvl;
   assign st_open  = (state == ST_ON) && short_lvl && cur_lvl;

   // R5
   short_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ON && !short_lvl) |=> !pwr_en);

   // R10
   no_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ON && short_lvl) |=> pwr_en);

   // R7
   wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT) |=> (state == ST_WAIT || state == ST_PROBE));

   // R8
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_fault && !fault_clr) |=> (st_fault && !pwr_en));

endmodule

// File: rtl/antenna_supervisor.sv
module antenna_supervisor #(
   parameter int SYNC_STAGES  = 2,
   parameter int DEB_CYCLES   = 16,
   parameter int RETRY_CYCLES = 50000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] strap_i,
   input  logic       short_n_i,
   input  logic       cur_a_n_i,
   input  logic       cur_b_n_i,
   input  logic       fault_clr_i,
   output logic       ant_pwr_o,
   output logic       ok_o,
   output logic       short_o,
   output logic       open_o,
   output logic       off_o,
   output logic       fault_o,
   output logic       cfg_err_o
);
   // Probe window covers filter latency so the reading at its end is fresh.
   localparam int PROBE_CYCLES = DEB_CYCLES + SYNC_STAGES + 2;

   logic cur_n_sel, short_lvl, cur_lvl;

   ant_src_sel u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .strap_i  (strap_i),
      .cur_a_n  (cur_a_n_i),
      .cur_b_n  (cur_b_n_i),
      .cur_n_o  (cur_n_sel),
      .cfg_err_o(cfg_err_o)
   );

   ant_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES), .RST_LVL(1'b1)) u_flt_short (
      .clk  (clk),
      .rst_n(rst_n),
      .raw_i(short_n_i),
      .lvl_o(short_lvl)
   );

   ant_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES), .RST_LVL(1'b0)) u_flt_cur (
      .clk  (clk),
      .rst_n(rst_n),
      .raw_i(cur_n_sel),
      .lvl_o(cur_lvl)
   );

   ant_sup_fsm #(.RETRY_CYCLES(RETRY_CYCLES), .PROBE_CYCLES(PROBE_CYCLES)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .short_lvl(short_lvl),
      .cur_lvl  (cur_lvl),
      .fault_clr(fault_clr_i),
      .pwr_en   (ant_pwr_o),
      .st_ok    (ok_o),
      .st_short (short_o),
      .st_open  (open_o),
      .st_off   (off_o),
      .st_fault (fault_o)
   );

   // R6
   open_needs_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open_o |-> ant_pwr_o);

endmodule

// File: tb/antenna_supervisor_test.sv
module antenna_supervisor_test;
   localparam int DEB   = 4;
   localparam int RETRY = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] strap = 3'b000;
   logic       short_n = 1'b1, cur_a_n = 1'b0, cur_b_n = 1'b1, fclr = 1'b0;
   logic       pwr, ok, sh, op, off, flt, cerr;
   int         checks = 0, failures = 0;

   always #4 clk = ~clk;

   antenna_supervisor #(.SYNC_STAGES(2), .DEB_CYCLES(DEB), .RETRY_CYCLES(RETRY)) uut (
      .clk(clk), .rst_n(rst_n), .strap_i(strap), .short_n_i(short_n),
      .cur_a_n_i(cur_a_n), .cur_b_n_i(cur_b_n), .fault_clr_i(fclr),
      .ant_pwr_o(pwr), .ok_o(ok), .short_o(sh), .open_o(op), .off_o(off),
      .fault_o(flt), .cfg_err_o(cerr)
   );

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [2:0] code);
      rst_n = 1'b0;
      strap = code;
      short_n = 1'b1; cur_a_n = 1'b0; cur_b_n = 1'b1; fclr = 1'b0;
      cyc(3);
      rst_n = 1'b1;
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      // R2: sweep all strap codes, antenna present on pin A only
      for (int c = 0; c < 8; c++) begin
         logic use_b, rsvd;
         do_reset(3'(c));
         cyc(12);
         use_b = (c == 2) || (c == 3) || (c == 4) || (c == 5);
         rsvd  = (c == 2) || (c == 4) || (c == 5);
         chk($sformatf("R2 open code=%0d", c), op, use_b);
         chk($sformatf("R2 cfg_err code=%0d", c), cerr, rsvd);
         chk($sformatf("R10 power kept code=%0d", c), pwr, 1'b1);
      end

      // R4: reset state
      do_reset(3'b000);
      cyc(1);
      chk("R4 pwr", pwr, 1'b1);
      chk("R4 ok", ok, 1'b1);
      chk("R4 short", sh, 1'b0);
      chk("R4 open", op, 1'b0);
      chk("R4 off", off, 1'b0);
      chk("R4 fault", flt, 1'b0);

      // R1: strap changes after reset are ignored
      strap = 3'b011;
      cyc(12);
      chk("R1 open after strap change", op, 1'b0);
      chk("R1 cfg_err after strap change", cerr, 1'b0);

      // R3: short glitch shorter than debounce
      short_n = 1'b0; cur_a_n = 1'b0;
      cyc(2);
      short_n = 1'b1;
      cyc(12);
      chk("R3 short glitch pwr", pwr, 1'b1);
      chk("R3 short glitch status", sh, 1'b0);

      // R3: current-sense glitch
      cur_a_n = 1'b1;
      cyc(2);
      cur_a_n = 1'b0;
      cyc(12);
      chk("R3 cur glitch open", op, 1'b0);

      // R10: sustained open
      cur_a_n = 1'b1;
      cyc(12);
      chk("R10 open", op, 1'b1);
      chk("R10 pwr", pwr, 1'b1);
      chk("R10 ok low", ok, 1'b0);
      cur_a_n = 1'b0;
      cyc(12);
      chk("R10 open cleared", op, 1'b0);

      // R5: sustained short trips supply
      short_n = 1'b0; cur_a_n = 1'b0;
      cyc(10);
      chk("R5 pwr off", pwr, 1'b0);
      chk("R5 short", sh, 1'b1);
      chk("R5 off", off, 1'b1);
      // R6: lows during off period
      cyc(12);
      chk("R6 still off", pwr, 1'b0);
      chk("R6 no fault", flt, 1'b0);
      chk("R6 no open", op, 1'b0);
      // R7: short removed before retry
      short_n = 1'b1;
      cyc(30);
      chk("R7 pwr back", pwr, 1'b1);
      chk("R7 ok", ok, 1'b1);
      chk("R7 short clear", sh, 1'b0);

      // R8: short persists through probe
      short_n = 1'b0;
      cyc(60);
      chk("R8 fault", flt, 1'b1);
      chk("R8 pwr off", pwr, 1'b0);
      chk("R8 short", sh, 1'b1);
      short_n = 1'b1;
      cyc(40);
      chk("R8 fault sticky", flt, 1'b1);
      chk("R8 pwr stays off", pwr, 1'b0);

      // R9: clear starts one probe, healthy line returns to ok
      fclr = 1'b1;
      cyc(1);
      fclr = 1'b0;
      chk("R9 probe pwr", pwr, 1'b1);
      cyc(15);
      chk("R9 fault cleared", flt, 1'b0);
      chk("R9 pwr", pwr, 1'b1);
      chk("R9 ok", ok, 1'b1);

      finish_run();
   end
endmodule